// File: doc/BRIEF.md
# Line-Card Alarm Interrupt Controller

This block turns a set of active-low line status signals into a single active-low interrupt for a host controller. Each channel has one alarm input and one detect input. A falling edge on an alarm input raises the interrupt directly. A falling edge on a detect input raises it only after the input has stayed low for a programmable number of clock cycles. A detect input that goes back high is seen at once, with no debounce.

Once raised, the interrupt stays low until it is released. The release rule depends on the power-down input. With power-down high, any low input that returns high releases the interrupt. With power-down low, the interrupt releases only when every input is high again. Independently of that mode, the host can release the interrupt by reading both per-channel status registers. The register reads arrive as single-cycle strobes in the clock domain. All line inputs are asynchronous and pass through two-flop synchronizers.

Top module: `lc_alarm_irq`

## Requirements
- R1: After reset, and with no falling event since, `irq_no` is 1 (released).
- R2: A 1-to-0 change on any alarm input drives `irq_no` to 0 on the third rising clock edge after the change: two synchronizer stages, then the interrupt register.
- R3: A detect input that goes low drives `irq_no` to 0 on the (DEB_CYCLES+3)th rising edge after the change, provided it stays low for at least DEB_CYCLES synchronized cycles. A shorter low pulse produces no event.
- R4: A detect input that returns to 1 is passed on without debounce. With power-down high, it releases an asserted interrupt on the fourth rising edge after the change.
- R5: With `pwr_down_i` = 1, an asserted interrupt releases when any one alarm or detect input that was low returns high. An alarm rise releases it on the third rising edge after the change.
- R6: With `pwr_down_i` = 0, an asserted interrupt stays low while any alarm or detect input is still low. It releases once all of them are high.
- R7: While the interrupt is asserted, a strobe on `rd_ch1_i` and a strobe on `rd_ch2_i`, in either order, release it on the edge that samples the second strobe. A single read does not release it. Strobes given while the interrupt is released are ignored.
- R8: A new falling event while the interrupt is asserted discards any read already recorded. Both registers must then be read again.
- R9: If a falling event and a release condition occur in the same cycle, the interrupt stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_ni | input | NUM_CH | Per-channel alarm status, active low, asynchronous |
| detect_ni | input | NUM_CH | Per-channel detect status, active low, asynchronous |
| pwr_down_i | input | 1 | Release mode: 1 = any input returning high releases, 0 = all inputs must be high |
| rd_ch1_i | input | 1 | Single-cycle strobe: host read of the channel-1 status register |
| rd_ch2_i | input | 1 | Single-cycle strobe: host read of the channel-2 status register |
| irq_no | output | 1 | Interrupt to host, active low |

## Verification
The hardest case to reach is a falling event landing in exactly the same cycle as a release condition. One variant has a rising and a falling line pass through the synchronizers together. The other has the second read strobe placed on the one edge where a freshly synchronized fall is visible. The bench times both by counting synchronizer stages from a negative-edge input change. The debounce threshold is found by sweeping detect pulse widths from one cycle to past the limit with a small debounce setting, while a monitor records any low on the interrupt. Every ordered pair of inputs is also swept under both power-down modes.

// File: rtl/lc_alarm_pkg.sv
package lc_alarm_pkg;
  typedef enum logic {
    REL_ALL_HIGH = 1'b0,
    REL_ANY_RISE = 1'b1
  } rel_mode_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lc_fall_filter.sv
module lc_fall_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CNT_W = lc_alarm_pkg::cnt_width(DEB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  // rising level passes at once; falling level must persist DEB_CYCLES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (lvl_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  assert_rise_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !lvl_q) |=> lvl_q);
  assert_fall_needs_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl_q) |-> !$past(lvl_i));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/lc_irq_core.sv
module lc_irq_core #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic                 pwr_down_i,
  input  logic                 rd_ch1_i,
  input  logic                 rd_ch2_i,
  output logic                 irq_act_o
);
  import lc_alarm_pkg::*;

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] fall, rise;
  logic                 irq_q, rd1_q, rd2_q;
  logic                 ev_fall, rd_done, lvl_rel, rel;
  rel_mode_e            mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign fall    = prev_q & ~lvl_i;
  assign rise    = ~prev_q & lvl_i;
  assign ev_fall = |fall;
  assign mode    = rel_mode_e'(pwr_down_i);

  always_comb begin
    unique case (mode)
      REL_ANY_RISE: lvl_rel = |rise;
      default:      lvl_rel = &lvl_i;
    endcase
  end

  assign rd_done = (rd1_q | rd_ch1_i) & (rd2_q | rd_ch2_i);
  assign rel     = irq_q & (lvl_rel | rd_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rd1_q <= 1'b0;
      rd2_q <= 1'b0;
    end else if (ev_fall) begin
      irq_q <= 1'b1;
      rd1_q <= 1'b0;
      rd2_q <= 1'b0;
    end else if (rel || !irq_q) begin
      irq_q <= 1'b0;
      rd1_q <= 1'b0;
      rd2_q <= 1'b0;
    end else begin
      rd1_q <= rd1_q | rd_ch1_i;
      rd2_q <= rd2_q | rd_ch2_i;
    end
  end

  assign irq_act_o = irq_q;

  assert_fall_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_fall |=> irq_q);
  assert_any_rise_rel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && pwr_down_i && (|rise) && !ev_fall) |=> !irq_q);
  assert_hold_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !pwr_down_i && !(&lvl_i) && !rd_done) |=> irq_q);
  assert_reads_rel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && rd_done && !ev_fall) |=> !irq_q);
  assert_idle_no_reads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q |-> (!rd1_q && !rd2_q));
  assert_new_fall_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_fall |=> (!rd1_q && !rd2_q));
endmodule

// File: rtl/lc_alarm_irq.sv
module lc_alarm_irq #(
  parameter int NUM_CH      = 2,
  parameter int DEB_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] alarm_ni,
  input  logic [NUM_CH-1:0] detect_ni,
  input  logic              pwr_down_i,
  input  logic              rd_ch1_i,
  input  logic              rd_ch2_i,
  output logic              irq_no
);
  localparam int NUM_LINES = 2 * NUM_CH;

  logic [NUM_CH-1:0]    alm_s, det_s, det_f;
  logic [NUM_LINES-1:0] lvl;
  logic                 irq_act;

  lc_sync #(.WIDTH(2*NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({detect_ni, alarm_ni}),
    .q_o   ({det_s, alm_s})
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_det
    lc_fall_filter #(.DEB_CYCLES(DEB_CYCLES)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (det_s[c]),
      .lvl_o (det_f[c])
    );
  end

  assign lvl = {det_f, alm_s};

  lc_irq_core #(.NUM_LINES(NUM_LINES)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .pwr_down_i(pwr_down_i),
    .rd_ch1_i  (rd_ch1_i),
    .rd_ch2_i  (rd_ch2_i),
    .irq_act_o (irq_act)
  );

  assign irq_no = ~irq_act;

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_no);
endmodule

// File: tb/test_lc_alarm_irq.sv
module test_lc_alarm_irq;
  localparam int DEB = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] lines = 4'hf;
  logic       pwr_down_i = 1'b0;
  logic       rd_ch1_i = 1'b0;
  logic       rd_ch2_i = 1'b0;
  logic       irq_no;
  int         checks = 0;
  int         errors = 0;
  bit         seen_low = 1'b0;
  bit         finished = 1'b0;

  always #4 clk_i = ~clk_i;

  lc_alarm_irq #(.NUM_CH(2), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) i_lc_alarm_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alarm_ni  (lines[1:0]),
    .detect_ni (lines[3:2]),
    .pwr_down_i(pwr_down_i),
    .rd_ch1_i  (rd_ch1_i),
    .rd_ch2_i  (rd_ch2_i),
    .irq_no    (irq_no)
  );

  always @(negedge clk_i) if (rst_ni && irq_no === 1'b0) seen_low = 1'b1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input int ch);
    if (ch == 1) rd_ch1_i = 1'b1; else rd_ch2_i = 1'b1;
    tick(1);
    rd_ch1_i = 1'b0;
    rd_ch2_i = 1'b0;
  endtask

  task automatic settle();
    lines = 4'hf;
    tick(DEB + 8);
    rd(1);
    rd(2);
    tick(2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    tick(2);
    chk(irq_no, 1'b1, "R1 in reset");
    rst_ni = 1'b1;
    tick(4);
    chk(irq_no, 1'b1, "R1 after reset");

    // alarm latency and rise release
    for (int k = 0; k < 2; k++) begin
      pwr_down_i = 1'b1;
      lines[k] = 1'b0;
      tick(2); chk(irq_no, 1'b1, "R2 before 3rd edge");
      tick(1); chk(irq_no, 1'b0, "R2 at 3rd edge");
      lines[k] = 1'b1;
      tick(2); chk(irq_no, 1'b0, "R5 before 3rd edge");
      tick(1); chk(irq_no, 1'b1, "R5 at 3rd edge");
      settle();
    end

    // detect latency and undebounced rise
    for (int k = 2; k < 4; k++) begin
      pwr_down_i = 1'b1;
      lines[k] = 1'b0;
      tick(DEB + 2); chk(irq_no, 1'b1, "R3 before debounce end");
      tick(1);       chk(irq_no, 1'b0, "R3 at debounce end");
      lines[k] = 1'b1;
      tick(3); chk(irq_no, 1'b0, "R4 before 4th edge");
      tick(1); chk(irq_no, 1'b1, "R4 at 4th edge");
      settle();
    end

    // debounce threshold sweep
    for (int k = 2; k < 4; k++) begin
      for (int len = 1; len <= DEB + 2; len++) begin
        pwr_down_i = 1'b1;
        seen_low = 1'b0;
        lines[k] = 1'b0;
        tick(len);
        lines[k] = 1'b1;
        tick(DEB + 8);
        chk(seen_low, (len >= DEB), "R3 pulse width sweep");
        settle();
      end
    end

    // release mode sweep over ordered pairs
    for (int pd = 0; pd < 2; pd++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          if (i != j) begin
            pwr_down_i = pd[0];
            lines[i] = 1'b0;
            tick(DEB + 6);
            chk(irq_no, 1'b0, (i < 2) ? "R2 pair first" : "R3 pair first");
            lines[j] = 1'b0;
            tick(DEB + 6);
            lines[i] = 1'b1;
            tick(8);
            chk(irq_no, pd[0], pd[0] ? "R5 one returns" : "R6 one returns");
            lines[j] = 1'b1;
            tick(8);
            chk(irq_no, 1'b1, pd[0] ? "R5 idle rise" : "R6 all high");
            settle();
          end
        end
      end
    end

    // fall and rise in the same cycle
    pwr_down_i = 1'b1;
    lines[0] = 1'b0;
    tick(6);
    lines[0] = 1'b1;
    lines[1] = 1'b0;
    tick(8);
    chk(irq_no, 1'b0, "R9 rise with fall");
    lines[1] = 1'b1;
    tick(8);
    chk(irq_no, 1'b1, "R5 after R9");
    settle();

    // reads: idle reads ignored, one read holds, second read releases
    pwr_down_i = 1'b0;
    rd(1);
    rd(2);
    lines[0] = 1'b0;
    tick(6);
    rd(1);
    tick(3);
    chk(irq_no, 1'b0, "R7 single read");
    rd(2);
    chk(irq_no, 1'b1, "R7 both reads");
    lines[0] = 1'b1;
    tick(6);
    chk(irq_no, 1'b1, "R7 idle after read release");
    settle();

    // new fall discards recorded read
    pwr_down_i = 1'b0;
    lines[0] = 1'b0;
    tick(6);
    rd(1);
    lines[1] = 1'b0;
    tick(6);
    chk(irq_no, 1'b0, "R8 new fall");
    rd(2);
    chk(irq_no, 1'b0, "R8 stale read dropped");
    rd(1);
    chk(irq_no, 1'b1, "R7 reads after R8");
    settle();

    // second read on the same edge as a new fall
    pwr_down_i = 1'b0;
    lines[0] = 1'b0;
    tick(6);
    rd(1);
    lines[1] = 1'b0;
    tick(2);
    rd(2);
    chk(irq_no, 1'b0, "R9 read with fall");
    rd(1);
    tick(2);
    chk(irq_no, 1'b0, "R8 read lost after fall");
    rd(2);
    chk(irq_no, 1'b1, "R7 release after R9");
    settle();

    finished = 1'b1;
    summary();
  end
endmodule